// File: doc/BRIEF.md
# Control OUT Endpoint Zero Register and Handshake Arbiter

This block holds the single control/status word for a USB device's control OUT endpoint zero. It also decides which handshake goes back to the host for every packet that arrives on that endpoint. Software reads and writes the word through a plain 32-bit register port with a write strobe. The protocol engine feeds the block with pulses: SETUP token seen, SETUP stage finished, transfer finished and endpoint disabled. It also supplies a level for the device-wide OUT NAK and a packet-valid indication that carries a SETUP/data qualifier.

Bit ownership is asymmetric. Software may raise the enable and STALL bits, and only hardware lowers them. NAK status has separate set and clear strobes that read back as zero, and hardware raises it on its own after a finished transfer or an accepted SETUP packet. A data packet gets STALL first, then NAK, then ACK. A SETUP packet is always accepted. The block also drives a snoop flag that tells the data path to skip packet checks, the decoded maximum packet size, and one-cycle interrupt strobes. Each strobe is raised only once the enable bit is already clear.

Top module: `ep0_out_ctrl`

## Requirements
- R1: Out of reset the register reads 0x0000_8000, snoop_o is 0 and mps_bytes_o is 64.
- R2: A write with bit 31 set sets the enable bit. A write with bit 31 clear leaves it unchanged.
- R3: A pulse on setup_done_i, xfer_done_i or ep_dis_i clears the enable bit at the next edge, and this clear wins over a software set in the same cycle. The matching irq strobe (irq_setup_o, irq_xfer_o, irq_dis_o) is high for exactly the cycle after the pulse, and in that cycle bit 31 already reads 0.
- R4: Bit 15 always reads 1. Bits 30:28, 27:22 except 21, 19:18, 16 and 14:2 always read 0, whatever is written.
- R5: Writing 1 to bit 27 sets NAK status and writing 1 to bit 26 clears it. NAK status reads at bit 17. If both bits are 1 in one write, NAK status is set.
- R6: NAK status is set at the next edge after xfer_done_i or an accepted SETUP packet (pkt_valid_i with pkt_is_setup_i). This hardware set wins over a clear strobe in the same cycle.
- R7: STALL (bit 21) is set by writing 1 and is unaffected by writing 0. setup_tok_i clears it at the next edge, winning over a same-cycle set.
- R8: For a data packet (pkt_valid_i=1, pkt_is_setup_i=0), hs_o is 2'b11 (STALL) when STALL is set. Otherwise it is 2'b10 (NAK) when NAK status or gonak_i is set, and otherwise 2'b01 (ACK). hs_o is 2'b00 when pkt_valid_i is 0.
- R9: For a SETUP packet hs_o is 2'b01 (ACK) regardless of STALL, NAK status or gonak_i.
- R10: Bit 20 is read/write and snoop_o equals its stored value.
- R11: Bits 1:0 are read/write. mps_bytes_o shows 64, 32, 16 or 8 for the codes 00, 01, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| setup_tok_i | input | 1 | SETUP token seen for this endpoint |
| setup_done_i | input | 1 | SETUP stage finished |
| xfer_done_i | input | 1 | Transfer finished |
| ep_dis_i | input | 1 | Endpoint disabled event |
| gonak_i | input | 1 | Device-wide OUT NAK level |
| pkt_valid_i | input | 1 | A packet needs a handshake this cycle |
| pkt_is_setup_i | input | 1 | Packet is a SETUP data packet |
| hs_o | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| snoop_o | output | 1 | Forward OUT packets without checks |
| mps_bytes_o | output | 7 | Decoded max packet size in bytes |
| irq_setup_o | output | 1 | SETUP-done interrupt strobe |
| irq_xfer_o | output | 1 | Transfer-done interrupt strobe |
| irq_dis_o | output | 1 | Endpoint-disabled interrupt strobe |

## Verification
Several properties are checked on every cycle. STALL-over-NAK ordering and unconditional SETUP ACK are checked against the handshake output. The enable bit must be already clear whenever an interrupt strobe is high, and the hardware clears of enable and STALL must land one cycle after their events. The constant bits and the one-hot packet-size decode are checked as well. Some behaviour only the bench scenarios can show: same-cycle collisions between software writes and hardware events, the set/clear strobe pair written together, write-0 having no effect on set-only bits, and every packet-size code.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned BIT_EN    = 31;
  localparam int unsigned BIT_SNAK  = 27;
  localparam int unsigned BIT_CNAK  = 26;
  localparam int unsigned BIT_STALL = 21;
  localparam int unsigned BIT_SNOOP = 20;
  localparam int unsigned BIT_NAKST = 17;
  localparam int unsigned BIT_ACT   = 15;
  localparam int unsigned MPS_W     = 2;
endpackage

// File: rtl/ep0_csr.sv
module ep0_csr
  import ep0_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hw_en_clr_i,
  input  logic             hw_nak_set_i,
  input  logic             stall_clr_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             nak_o,
  output logic             stall_o,
  output logic             snoop_o,
  output logic [MPS_W-1:0] mps_o
);
  logic en_q, nak_q, stall_q, snoop_q;
  logic [MPS_W-1:0] mps_q;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[30:28], wdata_i[25:22], wdata_i[19:MPS_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      nak_q   <= 1'b0;
      stall_q <= 1'b0;
      snoop_q <= 1'b0;
      mps_q   <= '0;
    end else begin
      // hardware clear outranks software set
      if (hw_en_clr_i)                   en_q <= 1'b0;
      else if (wr_i && wdata_i[BIT_EN])  en_q <= 1'b1;
      // any set source outranks the clear strobe
      if (hw_nak_set_i || (wr_i && wdata_i[BIT_SNAK]))  nak_q <= 1'b1;
      else if (wr_i && wdata_i[BIT_CNAK])               nak_q <= 1'b0;
      if (stall_clr_i)                      stall_q <= 1'b0;
      else if (wr_i && wdata_i[BIT_STALL])  stall_q <= 1'b1;
      if (wr_i) begin
        snoop_q <= wdata_i[BIT_SNOOP];
        mps_q   <= wdata_i[MPS_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[BIT_EN]     = en_q;
    rdata_o[BIT_STALL]  = stall_q;
    rdata_o[BIT_SNOOP]  = snoop_q;
    rdata_o[BIT_NAKST]  = nak_q;
    rdata_o[BIT_ACT]    = 1'b1;
    rdata_o[MPS_W-1:0]  = mps_q;
  end

  assign nak_o   = nak_q;
  assign stall_o = stall_q;
  assign snoop_o = snoop_q;
  assign mps_o   = mps_q;
endmodule

// File: rtl/ep0_hs_arb.sv
module ep0_hs_arb
  import ep0_pkg::*;
(
  input  logic pkt_valid_i,
  input  logic pkt_is_setup_i,
  input  logic stall_i,
  input  logic nak_i,
  input  logic gonak_i,
  output hs_e  hs_o
);
  always_comb begin
    if (!pkt_valid_i)         hs_o = HS_NONE;
    else if (pkt_is_setup_i)  hs_o = HS_ACK;
    else if (stall_i)         hs_o = HS_STALL;
    else if (nak_i || gonak_i) hs_o = HS_NAK;
    else                      hs_o = HS_ACK;
  end
endmodule

// File: rtl/ep0_irq.sv
module ep0_irq #(
  parameter int unsigned N_EV = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_EV-1:0] ev_i,
  output logic [N_EV-1:0] irq_o
);
  for (genvar g = 0; g < N_EV; g++) begin : g_strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[g] <= 1'b0;
      else         irq_o[g] <= ev_i[g];
    end
  end
endmodule

// File: rtl/ep0_out_ctrl.sv
module ep0_out_ctrl
  import ep0_pkg::*;
#(
  parameter int unsigned MPS_MAX = 64,
  localparam int unsigned MPSB_W = $clog2(MPS_MAX) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              setup_tok_i,
  input  logic              setup_done_i,
  input  logic              xfer_done_i,
  input  logic              ep_dis_i,
  input  logic              gonak_i,
  input  logic              pkt_valid_i,
  input  logic              pkt_is_setup_i,
  output logic [1:0]        hs_o,
  output logic              snoop_o,
  output logic [MPSB_W-1:0] mps_bytes_o,
  output logic              irq_setup_o,
  output logic              irq_xfer_o,
  output logic              irq_dis_o
);
  logic nak, stall;
  logic [MPS_W-1:0] mps;
  logic [2:0] irq;
  hs_e hs;

  ep0_csr u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (reg_wr_i),
    .wdata_i      (reg_wdata_i),
    .hw_en_clr_i  (setup_done_i | xfer_done_i | ep_dis_i),
    .hw_nak_set_i (xfer_done_i | (pkt_valid_i & pkt_is_setup_i)),
    .stall_clr_i  (setup_tok_i),
    .rdata_o      (reg_rdata_o),
    .nak_o        (nak),
    .stall_o      (stall),
    .snoop_o      (snoop_o),
    .mps_o        (mps)
  );

  ep0_hs_arb u_arb (
    .pkt_valid_i    (pkt_valid_i),
    .pkt_is_setup_i (pkt_is_setup_i),
    .stall_i        (stall),
    .nak_i          (nak),
    .gonak_i        (gonak_i),
    .hs_o           (hs)
  );

  ep0_irq #(.N_EV(3)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   ({ep_dis_i, xfer_done_i, setup_done_i}),
    .irq_o  (irq)
  );

  assign hs_o        = hs;
  assign mps_bytes_o = MPSB_W'(MPS_MAX >> mps);
  assign irq_setup_o = irq[0];
  assign irq_xfer_o  = irq[1];
  assign irq_dis_o   = irq[2];
endmodule

// File: rtl/ep0_out_ctrl_chk.sv
module ep0_out_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] reg_rdata_o,
  input logic        setup_tok_i,
  input logic        setup_done_i,
  input logic        xfer_done_i,
  input logic        ep_dis_i,
  input logic        pkt_valid_i,
  input logic        pkt_is_setup_i,
  input logic [1:0]  hs_o,
  input logic [6:0]  mps_bytes_o,
  input logic        irq_setup_o,
  input logic        irq_xfer_o,
  input logic        irq_dis_o
);
  a_r3_irq_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_setup_o || irq_xfer_o || irq_dis_o) |-> !reg_rdata_o[31]);

  a_r3_en_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_done_i || xfer_done_i || ep_dis_i) |=> !reg_rdata_o[31]);

  a_r2_en_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31] && !setup_done_i && !xfer_done_i && !ep_dis_i) |=> reg_rdata_o[31]);

  a_r7_stall_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_tok_i |=> !reg_rdata_o[21]);

  a_r6_nak_on_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> reg_rdata_o[17]);

  a_r8_stall_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !pkt_is_setup_i && reg_rdata_o[21]) |-> hs_o == 2'b11);

  a_r9_setup_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_is_setup_i) |-> hs_o == 2'b01);

  a_r4_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[15] && reg_rdata_o[30:22] == 9'd0 && reg_rdata_o[19:18] == 2'd0);

  a_r11_mps_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mps_bytes_o) == 1 && mps_bytes_o[2:0] == 3'd0);
endmodule

bind ep0_out_ctrl ep0_out_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_rdata_o    (reg_rdata_o),
  .setup_tok_i    (setup_tok_i),
  .setup_done_i   (setup_done_i),
  .xfer_done_i    (xfer_done_i),
  .ep_dis_i       (ep_dis_i),
  .pkt_valid_i    (pkt_valid_i),
  .pkt_is_setup_i (pkt_is_setup_i),
  .hs_o           (hs_o),
  .mps_bytes_o    (mps_bytes_o),
  .irq_setup_o    (irq_setup_o),
  .irq_xfer_o     (irq_xfer_o),
  .irq_dis_o      (irq_dis_o)
);

// File: tb/ep0_out_ctrl_tb.sv
`timescale 1ns/1ps
module ep0_out_ctrl_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic setup_tok_i = 0, setup_done_i = 0, xfer_done_i = 0, ep_dis_i = 0;
  logic gonak_i = 0, pkt_valid_i = 0, pkt_is_setup_i = 0;
  logic [1:0] hs_o;
  logic snoop_o;
  logic [6:0] mps_bytes_o;
  logic irq_setup_o, irq_xfer_o, irq_dis_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  bit m_en, m_nak, m_stall, m_snoop;
  int m_mps;
  bit m_irq[3];

  always #10 clk_i = ~clk_i;

  ep0_out_ctrl u_dut (.*);

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input logic [31:0] wd, input bit st, input bit sd,
                      input bit xd, input bit ed, input bit gn, input bit pv, input bit ps);
    int exp_hs;
    reg_wr_i = wr; reg_wdata_i = wd; setup_tok_i = st; setup_done_i = sd;
    xfer_done_i = xd; ep_dis_i = ed; gonak_i = gn; pkt_valid_i = pv; pkt_is_setup_i = ps;
    #1;
    cmp("R2/R3 enable", int'(reg_rdata_o[31]), int'(m_en));
    cmp("R5/R6 nak status", int'(reg_rdata_o[17]), int'(m_nak));
    cmp("R7 stall", int'(reg_rdata_o[21]), int'(m_stall));
    cmp("R4 fixed bits", int'(reg_rdata_o & ~32'h8032_0003), 32'h0000_8000);
    cmp("R10 snoop bit", int'(reg_rdata_o[20]), int'(m_snoop));
    cmp("R10 snoop_o", int'(snoop_o), int'(m_snoop));
    cmp("R11 mps field", int'(reg_rdata_o[1:0]), m_mps);
    cmp("R11 mps bytes", int'(mps_bytes_o), 64 / (1 << m_mps));
    cmp("R3 irq strobes", int'({irq_dis_o, irq_xfer_o, irq_setup_o}),
        (int'(m_irq[2]) << 2) | (int'(m_irq[1]) << 1) | int'(m_irq[0]));
    if (!pv) exp_hs = 0;
    else if (ps) exp_hs = 1;
    else if (m_stall) exp_hs = 3;
    else if (m_nak || gn) exp_hs = 2;
    else exp_hs = 1;
    cmp(ps ? "R9 setup handshake" : "R8 data handshake", int'(hs_o), exp_hs);
    @(posedge clk_i);
    if (sd || xd || ed) m_en = 0;
    else if (wr && wd[31]) m_en = 1;
    if (xd || (pv && ps) || (wr && wd[27])) m_nak = 1;
    else if (wr && wd[26]) m_nak = 0;
    if (st) m_stall = 0;
    else if (wr && wd[21]) m_stall = 1;
    if (wr) begin m_snoop = wd[20]; m_mps = int'(wd[1:0]); end
    m_irq[0] = sd; m_irq[1] = xd; m_irq[2] = ed;
    @(negedge clk_i);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [31:0] d); step(1, d, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic pkt(input bit setup, input bit gn); step(0, 0, 0, 0, 0, 0, gn, 1, setup); endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset value
    cmp("R1 reset word", int'(reg_rdata_o), 32'h0000_8000);
    cmp("R1 reset snoop", int'(snoop_o), 0);
    cmp("R1 reset mps bytes", int'(mps_bytes_o), 64);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle();
    pkt(0, 0);                       // R8 ACK when idle
    pkt(0, 1);                       // R8 global NAK
    wr(32'h8000_0000);               // R2 set enable
    wr(32'h0000_0000);               // R2 write 0 keeps enable, R7 stall stays 0
    wr(32'hFFFF_FFFF);               // R4 ignored bits, R5 both strobes -> set, R7 set
    idle();
    wr(32'h0000_0000);               // R7 write 0 has no effect
    pkt(0, 0);                       // R8 STALL outranks NAK
    pkt(0, 1);
    pkt(1, 1);                       // R9 SETUP still ACK
    step(1, 32'h0020_0000, 1, 0, 0, 0, 0, 0, 0); // R7 clear beats set
    pkt(0, 0);                       // R8 NAK now
    wr(32'h0400_0000);               // R5 clear strobe
    pkt(0, 0);                       // R8 ACK
    pkt(1, 0);                       // R6 SETUP packet sets NAK
    wr(32'h0400_0000);
    step(1, 32'h8400_0000, 0, 0, 1, 0, 0, 0, 0); // R3/R6 xfer beats set/clear
    idle();
    wr(32'h8400_0000);
    step(1, 32'h8000_0000, 0, 1, 0, 0, 0, 0, 0); // R3 setup done
    idle();
    wr(32'h8000_0000);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);             // R3 endpoint disabled
    idle();
    wr(32'h0010_0001);               // R10 snoop, R11 code 01
    wr(32'h0000_0002);               // R11 code 10
    wr(32'h0000_0003);               // R11 code 11
    wr(32'h0000_0000);
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule